// File: doc/BRIEF.md
# Programmable Down-Count Interval Timer

This block is a general-purpose down counter for a larger device. A host programs a reload value through two byte-wide registers and a control register. The control register picks the tick source (an oscillator tick enable already in the system clock domain, or an asynchronous external clock pin), starts and stops counting, chooses between one-shot and auto-reload behaviour, and gates the interrupt request.

On each qualified tick the running counter steps down by one. When the last tick of an interval arrives, the block emits a one-cycle time-out pulse. In one-shot mode it stops. In auto-reload mode it reloads and continues. If the interrupt is enabled, a sticky pending flag is also set, and a host read of the control register acknowledges it. The time-out pulse can replace the host-driven level on general-purpose pin 0.

Top module: `pgm_down_timer`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, `irq` and `timeout_pulse` are 0, and `gpio0_out` follows `gpio0_level`.
- R2: Address 1 holds the low byte and address 2 the high byte of the reload value N = {high, low}. Both read back as written. After a start, exactly N qualified ticks produce one time-out.
- R3: Control bit layout: bit 0 is interrupt enable, bit 1 is run, bit 2 is mode, bit 4 is tick source, and bit 7 is a read-only pending flag. Other bits read 0. The counter loads from the reload registers only when a write sets run while run is clear. Writing run=1 while already running does not restart the interval.
- R4: Tick source bit 4 = 0 counts the `osc_tick` enable. Bit 4 = 1 counts rising edges of `ext_clk_pin` after a two-flop synchroniser. The unselected source has no effect.
- R5: With mode bit 2 = 0 (one-shot), the first time-out clears the run bit, and no further time-out occurs.
- R6: With mode bit 2 = 1 (auto-reload), the counter reloads on time-out and times out every N ticks.
- R7: While run is clear, ticks produce no time-out.
- R8: A time-out sets the pending flag (control bit 7) only when bit 0 is 1. `irq` is high when pending and bit 0 are both set.
- R9: A read of address 0 clears the pending flag. A time-out in the same cycle as the read leaves the flag set.
- R10: A reload value of 0 gives an interval of 65536 ticks.
- R11: Writes to the reload bytes during counting affect only the next reload.
- R12: With `gpio0_route` = 1, `gpio0_out` equals `timeout_pulse`. Otherwise it equals `gpio0_level`.
- R13: `timeout_pulse` is high for exactly the one cycle after the clock edge that takes the final tick of an interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| osc_tick | input | 1 | Internal oscillator tick enable (system clock domain) |
| ext_clk_pin | input | 1 | Asynchronous external count clock |
| gpio0_route | input | 1 | Selects time-out pulse onto pin 0 |
| gpio0_level | input | 1 | Host level for pin 0 when not routed |
| irq | output | 1 | Interrupt request |
| timeout_pulse | output | 1 | One-cycle time-out pulse |
| gpio0_out | output | 1 | General-purpose pin 0 output |

## Verification
The counting path is driven with sparse oscillator ticks and with idle cycles between them. These show that the block counts ticks and not clock cycles. It is also driven with slow external pin edges interleaved with oscillator ticks, which shows that only the selected source reaches the counter. Directed sequences cover one-shot versus auto-reload periods, a zero reload of 65536 ticks, reload changes in mid-interval, a repeated start while running, and a read that collides with a time-out. A seeded random mix of ticks, reload writes, control writes and acknowledging reads then compares the pulse, interrupt and read data against a bench model. That mix exposes ordering errors between reload, stop and acknowledge.

// File: rtl/gdt_pkg.sv
package gdt_pkg;
   localparam int unsigned BUS_AW     = 2;
   localparam int unsigned BUS_DW     = 8;
   localparam int unsigned BIT_IEN    = 0;
   localparam int unsigned BIT_RUN    = 1;
   localparam int unsigned BIT_MODE   = 2;
   localparam int unsigned BIT_CLKSEL = 4;
   localparam int unsigned BIT_PEND   = 7;

   typedef enum logic [BUS_AW-1:0] {
      REG_CTRL   = 2'd0,
      REG_RLD_LO = 2'd1,
      REG_RLD_HI = 2'd2,
      REG_SPARE  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic clk_ext;
      logic retrig;
      logic run;
      logic ien;
   } ctrl_t;
endpackage

// File: rtl/gdt_tick_sel.sv
module gdt_tick_sel #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EXT_ENABLE  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_tick,
   input  logic ext_clk_pin,
   input  logic use_ext,
   output logic tick
);
   localparam int unsigned MSB = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic ext_edge;

   if (EXT_ENABLE) begin : g_ext
      logic [MSB:0] sync_q;
      logic         last_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
         end else begin
            sync_q <= {sync_q[MSB-1:0], ext_clk_pin};
            last_q <= sync_q[MSB];
         end
      end
      assign ext_edge = sync_q[MSB] & ~last_q;

      AST_EXT_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         ext_edge |=> !ext_edge); // R4
   end else begin : g_no_ext
      assign ext_edge = 1'b0;
   end

   assign tick = use_ext ? ext_edge : osc_tick;
endmodule

// File: rtl/gdt_regs.sv
module gdt_regs
   import gdt_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [BUS_AW-1:0]   addr,
   input  logic [BUS_DW-1:0]   wdata,
   input  logic                pending,
   input  logic                oneshot_done,
   output logic [BUS_DW-1:0]   rdata,
   output ctrl_t               ctrl,
   output logic                start_pulse,
   output logic                ctrl_ack,
   output logic [CNT_W-1:0]    reload
);
   localparam int unsigned HI_W = CNT_W - BUS_DW;

   ctrl_t              ctrl_q;
   logic [BUS_DW-1:0]  lo_q;
   logic [HI_W-1:0]    hi_q;
   logic               ctrl_wr;

   assign ctrl_wr     = wr_en && (addr == REG_CTRL);
   assign start_pulse = ctrl_wr && wdata[BIT_RUN] && !ctrl_q.run;
   assign ctrl_ack    = rd_en && (addr == REG_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q.clk_ext <= wdata[BIT_CLKSEL];
         ctrl_q.retrig  <= wdata[BIT_MODE];
         ctrl_q.run     <= wdata[BIT_RUN];
         ctrl_q.ien     <= wdata[BIT_IEN];
      end else if (oneshot_done) begin
         ctrl_q.run <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (wr_en) begin
         if (addr == REG_RLD_LO) lo_q <= wdata;
         if (addr == REG_RLD_HI) hi_q <= wdata[HI_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      unique case (reg_sel_e'(addr))
         REG_CTRL: begin
            rdata[BIT_PEND]   = pending;
            rdata[BIT_CLKSEL] = ctrl_q.clk_ext;
            rdata[BIT_MODE]   = ctrl_q.retrig;
            rdata[BIT_RUN]    = ctrl_q.run;
            rdata[BIT_IEN]    = ctrl_q.ien;
         end
         REG_RLD_LO: rdata = lo_q;
         REG_RLD_HI: rdata[HI_W-1:0] = hi_q;
         default:    rdata = '0;
      endcase
   end

   assign ctrl   = ctrl_q;
   assign reload = {hi_q, lo_q};

   AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (oneshot_done && !ctrl_wr) |=> !ctrl_q.run); // R5
endmodule

// File: rtl/gdt_counter.sv
module gdt_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             retrig,
   input  logic             ien,
   input  logic             load,
   input  logic [CNT_W-1:0] reload,
   input  logic             irq_ack,
   output logic             timeout_q,
   output logic             oneshot_done,
   output logic             pending_q
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic [CNT_W-1:0] count_q;
   logic             expire;

   assign expire       = tick && run && (count_q == LAST);
   assign oneshot_done = expire && !retrig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= reload;
      end else if (tick && run) begin
         count_q <= expire ? reload : count_q - LAST;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timeout_q <= 1'b0;
         pending_q <= 1'b0;
      end else begin
         timeout_q <= expire;
         if (expire && ien)  pending_q <= 1'b1;
         else if (irq_ack)   pending_q <= 1'b0;
      end
   end

   AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending_q) |-> $past(ien)); // R8
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq_ack) && !$past(expire)) |-> !pending_q); // R9
   AST_PULSE_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_q |-> $past(tick && run)); // R13
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!run) && !$past(load)) |-> $stable(count_q)); // R7
endmodule

// File: rtl/pgm_down_timer.sv
module pgm_down_timer
   import gdt_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EXT_ENABLE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   input  logic              osc_tick,
   input  logic              ext_clk_pin,
   input  logic              gpio0_route,
   input  logic              gpio0_level,
   output logic              irq,
   output logic              timeout_pulse,
   output logic              gpio0_out
);
   if (CNT_W < BUS_DW + 1 || CNT_W > 2 * BUS_DW) begin : g_bad_width
      $error("CNT_W must lie between 9 and 16");
   end

   ctrl_t            ctrl;
   logic             tick;
   logic             start_pulse;
   logic             ctrl_ack;
   logic             oneshot_done;
   logic             pending;
   logic [CNT_W-1:0] reload;

   gdt_tick_sel #(.SYNC_STAGES(SYNC_STAGES), .EXT_ENABLE(EXT_ENABLE)) u_tick (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ext_clk_pin(ext_clk_pin),
      .use_ext(ctrl.clk_ext), .tick(tick)
   );

   gdt_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
      .wdata(bus_wdata), .pending(pending), .oneshot_done(oneshot_done),
      .rdata(bus_rdata), .ctrl(ctrl), .start_pulse(start_pulse),
      .ctrl_ack(ctrl_ack), .reload(reload)
   );

   gdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl.run), .retrig(ctrl.retrig),
      .ien(ctrl.ien), .load(start_pulse), .reload(reload), .irq_ack(ctrl_ack),
      .timeout_q(timeout_pulse), .oneshot_done(oneshot_done), .pending_q(pending)
   );

   assign irq       = pending & ctrl.ien;
   assign gpio0_out = gpio0_route ? timeout_pulse : gpio0_level;

   AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> bus_rdata[BIT_PEND] || (bus_addr != REG_CTRL)); // R8
endmodule

// File: tb/test_pgm_down_timer.sv
module test_pgm_down_timer;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       bus_wr = 0, bus_rd = 0;
   logic [1:0] bus_addr = 0;
   logic [7:0] bus_wdata = 0, bus_rdata;
   logic       osc_tick = 0, ext_clk_pin = 0, gpio0_route = 0, gpio0_level = 1;
   logic       irq, timeout_pulse, gpio0_out;

   int checks = 0, fails = 0;

   bit        m_ien, m_run, m_rt, m_clk, m_pend;
   logic [7:0] m_lo, m_hi;
   logic [15:0] m_cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgm_down_timer i_pgm_down_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_tick(osc_tick),
      .ext_clk_pin(ext_clk_pin), .gpio0_route(gpio0_route), .gpio0_level(gpio0_level),
      .irq(irq), .timeout_pulse(timeout_pulse), .gpio0_out(gpio0_out)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_ctrl();
      return {m_pend, 2'b00, m_clk, 1'b0, m_rt, m_run, m_ien};
   endfunction

   // returns 1 when the model times out on this tick
   function automatic bit model_tick();
      if (!m_run) return 0;
      if (m_cnt == 16'd1) begin
         m_cnt = {m_hi, m_lo};
         if (m_ien) m_pend = 1;
         if (!m_rt) m_run = 0;
         return 1;
      end
      m_cnt = m_cnt - 16'd1;
      return 0;
   endfunction

   task automatic bus_write(logic [1:0] a, logic [7:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_wr = 0;
      case (a)
         2'd0: begin
            m_ien = d[0]; m_rt = d[2]; m_clk = d[4];
            if (d[1] && !m_run) m_cnt = {m_hi, m_lo};
            m_run = d[1];
         end
         2'd1: m_lo = d;
         2'd2: m_hi = d;
         default: ;
      endcase
   endtask

   task automatic bus_read(logic [1:0] a, output logic [7:0] d);
      bus_rd = 1; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_rd = 0;
      if (a == 2'd0) m_pend = 0;
   endtask

   task automatic read_ctrl_check(string req);
      logic [7:0] d;
      logic [7:0] e;
      e = exp_ctrl();
      bus_read(2'd0, d);
      check(req, d, e);
   endtask

   task automatic osc_step(bit t, string req);
      bit e;
      osc_tick = t;
      @(posedge clk); @(negedge clk);
      osc_tick = 0;
      e = (t && !m_clk) ? model_tick() : 1'b0;
      check(req, timeout_pulse, e);
      check("R8 irq", irq, m_pend & m_ien);
      check("R12 gpio0", gpio0_out, gpio0_route ? e : gpio0_level);
   endtask

   task automatic ext_step(string req);
      int seen = 0;
      bit e;
      ext_clk_pin = 1;
      repeat (4) begin @(posedge clk); @(negedge clk); seen += int'(timeout_pulse); end
      ext_clk_pin = 0;
      repeat (4) begin @(posedge clk); @(negedge clk); seen += int'(timeout_pulse); end
      e = m_clk ? model_tick() : 1'b0;
      check(req, seen, int'(e));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'd4711));
      {m_ien, m_run, m_rt, m_clk, m_pend} = '0;
      m_lo = 0; m_hi = 0; m_cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      read_ctrl_check("R1 ctrl reset");
      check("R1 irq", irq, 0);
      check("R1 pulse", timeout_pulse, 0);
      check("R1 gpio0", gpio0_out, 1);

      // R2 reload bytes
      bus_write(2'd1, 8'h03);
      bus_write(2'd2, 8'h00);
      bus_read(2'd1, d); check("R2 low byte", d, 8'h03);
      bus_read(2'd2, d); check("R2 high byte", d, 8'h00);

      // R3 bit layout with 0xE8 (no defined bits) then stopped
      bus_write(2'd0, 8'hE8);
      read_ctrl_check("R3 unused bits read 0");
      bus_write(2'd0, 8'h00);

      // R5 one-shot, R13 single pulse per interval, R8 pending
      bus_write(2'd0, 8'h03);
      repeat (3) osc_step(1, "R2 R13 one-shot count");
      read_ctrl_check("R5 R8 run cleared pending set");
      check("R9 irq cleared", irq, 0);
      repeat (5) osc_step(1, "R5 no second time-out");

      // R6 auto-reload with idle cycles, R3 restart ignored while running
      bus_write(2'd1, 8'h02);
      bus_write(2'd0, 8'h07);
      for (int i = 0; i < 6; i++) begin
         osc_step(1, "R6 periodic");
         osc_step(0, "R6 idle cycle");
      end
      osc_step(1, "R3 pre");
      bus_write(2'd0, 8'h07);
      osc_step(1, "R3 rewrite run keeps interval");
      read_ctrl_check("R6 pending");

      // R7 stopped
      bus_write(2'd0, 8'h05);
      repeat (6) osc_step(1, "R7 stopped no time-out");

      // R8 interrupt disabled
      bus_write(2'd0, 8'h06);
      repeat (5) osc_step(1, "R8 time-out without ien");
      read_ctrl_check("R8 no pending");

      // R11 reload change mid-interval, R12 routing
      gpio0_route = 1;
      bus_write(2'd0, 8'h00);
      bus_write(2'd1, 8'h04);
      bus_write(2'd0, 8'h07);
      osc_step(1, "R11 a");
      bus_write(2'd1, 8'h02);
      repeat (9) osc_step(1, "R11 R12 new reload next interval");
      gpio0_route = 0;

      // R9 read colliding with time-out
      read_ctrl_check("R9 pre");
      while (m_cnt != 16'd1) osc_step(1, "R9 align");
      bus_rd = 1; bus_addr = 2'd0; osc_tick = 1;
      #1 check("R9 collide read", bus_rdata, exp_ctrl());
      @(posedge clk); @(negedge clk);
      bus_rd = 0; osc_tick = 0;
      void'(model_tick());
      check("R9 time-out wins over read", irq, 1);
      read_ctrl_check("R9 pending still set");

      // R4 external source, osc ignored
      bus_write(2'd0, 8'h00);
      bus_write(2'd1, 8'h03);
      bus_write(2'd0, 8'h17);
      for (int i = 0; i < 7; i++) begin
         ext_step("R4 external edge count");
         osc_step(1, "R4 osc ignored in ext mode");
      end
      bus_write(2'd0, 8'h00);
      bus_write(2'd0, 8'h07);
      repeat (3) ext_step("R4 ext ignored in osc mode");
      osc_step(1, "R4 osc counts");
      read_ctrl_check("R4 readback");

      // R10 zero reload = 65536
      bus_write(2'd0, 8'h00);
      bus_write(2'd1, 8'h00);
      bus_write(2'd0, 8'h03);
      begin
         int hits = 0, at = 0;
         osc_tick = 1;
         for (int i = 1; i <= 65540; i++) begin
            @(posedge clk); @(negedge clk);
            if (timeout_pulse) begin hits++; at = i; end
         end
         osc_tick = 0;
         check("R10 one time-out", hits, 1);
         check("R10 at tick 65536", at, 65536);
         m_run = 0; m_pend = 1; m_cnt = 0;
         read_ctrl_check("R10 ctrl after");
      end

      // random mix
      bus_write(2'd1, 8'h03);
      for (int i = 0; i < 400; i++) begin
         int unsigned r = $urandom_range(0, 9);
         if (r < 6)       osc_step($urandom_range(0, 3) != 0, "R6 R5 random tick");
         else if (r == 6) bus_write(2'd1, 8'($urandom_range(1, 6)));
         else if (r == 7) bus_write(2'd0, 8'($urandom_range(0, 7)) | 8'hE8);
         else             read_ctrl_check("R9 random read");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule